// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

This block recovers HDLC frames from a line-side bit stream. Bits arrive either one per strobe on a serial input or as whole octets that the block shifts out internally. The receiver searches the stream for an opening flag and strips the zero bits a transmitter inserted after runs of five ones. It packs the remaining bits into octets and runs a CRC-CCITT over every octet of the frame. At each closing flag or abort it reports one status code together with the frame length.

Payload octets leave on a byte stream with a valid strobe. A start-of-frame mark rides on the first payload octet. The two check octets at the end of a good frame are never emitted. Frame completion is signalled on a separate end strobe that carries the status code and the length. Two configuration inputs affect the octet path only. One makes the block take just seven bits from each octet, as needed on 56 kbit/s bit-robbed lines. The other reverses the bit order of each octet before it is used.

Top module: `hdlc_rx`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `out_valid` and `out_eof` are 0 and `oct_ready` is 1. The receiver then hunts for a flag.
- R2: Bits that come before the first flag (0, six 1s, 0) produce no output octet and no end strobe.
- R3: While the receiver is hunting, an offered octet equal to 0xFF is dropped whole, and `oct_ready` stays 1. Any other accepted octet makes `oct_ready` 0 in the next cycle, while its bits are shifted out.
- R4: Inside a frame, a 0 that follows five consecutive 1s is removed and is not stored as data.
- R5: A flag that closes a frame also opens the next one, so back-to-back frames that share a single flag are both received.
- R6: Seven consecutive 1s inside a frame that already holds at least one octet end it with status 3 (abort), and `out_len` gives the octets received. The receiver returns to hunting. The last two received octets of an aborted frame are never emitted.
- R7: Data bits are taken least significant bit first. Eight kept bits form one octet.
- R8: The CRC register is preset to 0xFFFF at frame start and advanced per octet with the reflected polynomial 0x8408. A closed frame whose final value is 0xF0B8 gets status 0 (good). Any other value gets status 1 (CRC error), with `out_len` equal to all received octets.
- R9: A closed frame holding exactly one octet gets status 2 (framing error) with `out_len` 1, and emits no octet.
- R10: For a good frame, `out_len` equals the octets received minus two. Exactly the payload octets, without the two check octets, appear on `out_data`.
- R11: `out_sof` is 1 only together with the first emitted octet of a frame. `out_eof` pulses once per reported frame, never in the same cycle as `out_valid`.
- R12: With `cfg_adapt56` set, each octet supplies only seven bits and the last bit in sending order is ignored: bit 7 normally, bit 0 when reversed.
- R13: With `cfg_bitrev` clear, octet bit 0 is sent first. With it set, bit 7 is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_adapt56 | input | 1 | Take seven bits per input octet |
| cfg_bitrev | input | 1 | Send each input octet most significant bit first |
| bit_valid | input | 1 | Serial bit strobe, honoured while `oct_ready` is 1 |
| bit_in | input | 1 | Serial line bit |
| oct_valid | input | 1 | Octet offered, taken when `oct_ready` is 1 |
| oct_in | input | 8 | Line octet |
| oct_ready | output | 1 | Octet path idle |
| out_valid | output | 1 | Payload octet strobe |
| out_data | output | 8 | Payload octet |
| out_sof | output | 1 | First payload octet of a frame |
| out_eof | output | 1 | Frame report strobe |
| out_status | output | 2 | 0 good, 1 CRC error, 2 framing error, 3 abort |
| out_len | output | LEN_W | Reported frame length in octets |

## Verification
The hardest case to reach from the ports is the idle-octet skip in the middle of a flag hunt. It only shows when the hunter holds a partial run of ones at the moment an all-ones octet arrives on the octet path. The bench gets there in three steps. It feeds a zero and five ones on the serial input, then offers 0xFF as an octet, then completes the flag with a one and a zero. A frame is then expected only if the octet was discarded. The frame sweeps also run every stuffed pattern through all four octet-path configurations, with the ignored 56k bit set to alternating values.

// File: rtl/hdlc_rx_pkg.sv
// Shared types and the per-octet CRC step for the HDLC receiver.
// Assumes reflected CRC-CCITT processing, data least significant bit first.
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        HS_ZERO = 2'd0,   // waiting for the leading 0 of a flag
        HS_ONES = 2'd1,   // counting the 1s of a candidate flag
        HS_LAST = 2'd2,   // six 1s seen, a 0 completes the flag
        HS_DATA = 2'd3    // inside a frame
    } hunt_st_t;

    typedef enum logic [1:0] {
        FS_GOOD    = 2'd0,
        FS_CRC     = 2'd1,
        FS_FRAMING = 2'd2,
        FS_ABORT   = 2'd3
    } frame_st_t;

    // Advance a reflected CRC by one octet.
    function automatic logic [15:0] crc_octet(input logic [15:0] c,
                                              input logic [7:0]  d,
                                              input logic [15:0] poly);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_ser.sv
// Octet-to-bit front end.
// Merges the serial bit input with octets shifted out one bit per cycle.
// An octet is optionally bit-reversed, sends seven or eight bits, and is
// dropped whole when it is 0xFF while the deframer hunts.
// Assumes serial bits are offered only while oct_ready is high.
module hdlc_rx_ser #(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_adapt56,
    input  logic             cfg_bitrev,
    input  logic             hunting,
    input  logic             oct_valid,
    input  logic [OCT_W-1:0] oct_in,
    output logic             oct_ready,
    input  logic             sbit_valid,
    input  logic             sbit_in,
    output logic             lbit_valid,
    output logic             lbit
);
    localparam int CNT_W = $clog2(OCT_W + 1);

    logic [OCT_W-1:0] rev_oct;
    logic [OCT_W-1:0] norm_oct;
    logic [OCT_W-1:0] sreg;
    logic [CNT_W-1:0] left;
    logic             take;
    logic             idle_oct;

    // Mirror the octet bit order.
    for (genvar i = 0; i < OCT_W; i++) begin : g_rev
        assign rev_oct[i] = oct_in[OCT_W-1-i];
    end

    assign norm_oct  = cfg_bitrev ? rev_oct : oct_in;
    assign oct_ready = (left == '0);
    assign take      = oct_valid && oct_ready;
    assign idle_oct  = hunting && (oct_in == {OCT_W{1'b1}});

    // Load an accepted octet and shift it out one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            left <= '0;
        end else if (take && !idle_oct) begin
            sreg <= norm_oct;
            left <= cfg_adapt56 ? CNT_W'(OCT_W - 1) : CNT_W'(OCT_W);
        end else if (left != '0) begin
            sreg <= sreg >> 1;
            left <= left - 1'b1;
        end
    end

    // Select the bit the deframer sees this cycle.
    always_comb begin
        if (left != '0) begin
            lbit_valid = 1'b1;
            lbit       = sreg[0];
        end else begin
            lbit_valid = sbit_valid;
            lbit       = sbit_in;
        end
    end

endmodule

// File: rtl/hdlc_rx_deframe.sv
// Flag hunter, zero-bit destuffer and octet assembler.
// Emits single-cycle events: frame open, octet done, close by flag and
// abort. Close and abort fire only when the frame holds an octet.
// Assumes at most one line bit per cycle.
module hdlc_rx_deframe
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lbit_valid,
    input  logic             lbit,
    output logic             hunting,
    output logic             frame_open,
    output logic             oct_done,
    output logic [7:0]       oct_data,
    output logic             frame_close,
    output logic             frame_abort,
    output logic [LEN_W-1:0] oct_count
);
    localparam logic [2:0] RUN_STUFF = 3'd5;
    localparam logic [2:0] RUN_FLAG  = 3'd6;

    hunt_st_t         st, st_n;
    logic [2:0]       ones, ones_n;
    logic [2:0]       nbits, nbits_n;
    logic [7:0]       shreg, shreg_n;
    logic [LEN_W-1:0] count, count_n;
    logic             take_bit;

    assign hunting   = (st != HS_DATA);
    assign oct_count = count;
    assign oct_data  = {lbit, shreg[7:1]};

    // Next-state decode for hunting, destuffing and octet packing.
    always_comb begin
        st_n        = st;
        ones_n      = ones;
        nbits_n     = nbits;
        shreg_n     = shreg;
        count_n     = count;
        take_bit    = 1'b0;
        frame_open  = 1'b0;
        oct_done    = 1'b0;
        frame_close = 1'b0;
        frame_abort = 1'b0;
        if (lbit_valid) begin
            unique case (st)
                HS_ZERO: begin
                    if (!lbit) begin
                        st_n   = HS_ONES;
                        ones_n = '0;
                    end
                end
                HS_ONES: begin
                    if (lbit) begin
                        ones_n = ones + 3'd1;
                        if (ones == RUN_STUFF) st_n = HS_LAST;
                    end else begin
                        ones_n = '0;
                    end
                end
                HS_LAST: begin
                    if (lbit) begin
                        st_n = HS_ZERO;
                    end else begin
                        st_n       = HS_DATA;
                        frame_open = 1'b1;
                        ones_n     = '0;
                        nbits_n    = '0;
                        count_n    = '0;
                    end
                end
                default: begin
                    if (lbit) begin
                        if (ones == RUN_FLAG) begin
                            frame_abort = (count != '0);
                            st_n        = HS_ZERO;
                            ones_n      = '0;
                        end else begin
                            ones_n   = ones + 3'd1;
                            take_bit = (ones != RUN_STUFF);
                        end
                    end else if (ones == RUN_STUFF) begin
                        ones_n = '0;
                    end else if (ones == RUN_FLAG) begin
                        frame_close = (count != '0);
                        frame_open  = 1'b1;
                        ones_n      = '0;
                        nbits_n     = '0;
                        count_n     = '0;
                    end else begin
                        ones_n   = '0;
                        take_bit = 1'b1;
                    end
                end
            endcase
        end
        if (take_bit) begin
            shreg_n = {lbit, shreg[7:1]};
            nbits_n = nbits + 3'd1;
            if (nbits == 3'd7) begin
                oct_done = 1'b1;
                if (count != {LEN_W{1'b1}}) count_n = count + 1'b1;
            end
        end
    end

    // Hold the hunter and packer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= HS_ZERO;
            ones  <= '0;
            nbits <= '0;
            shreg <= '0;
            count <= '0;
        end else begin
            st    <= st_n;
            ones  <= ones_n;
            nbits <= nbits_n;
            shreg <= shreg_n;
            count <= count_n;
        end
    end

endmodule

// File: rtl/hdlc_rx_crc.sv
// Per-octet CRC accumulator.
// Presets on frame open and advances on each completed octet.
// Assumes open and octet-done never coincide.
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h8408,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        preset,
    input  logic        advance,
    input  logic [7:0]  octet,
    output logic [15:0] crc
);
    // Keep the running check value of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= INIT;
        end else if (preset) begin
            crc <= INIT;
        end else if (advance) begin
            crc <= crc_octet(crc, octet, POLY);
        end
    end

endmodule

// File: rtl/hdlc_rx.sv
// HDLC receiver top.
// Chains the octet front end, the deframer and the CRC. Two octets are held
// back, so the check octets of a frame never reach the byte stream. Each
// closed or aborted frame gets one status code.
// Assumes the consumer always takes out_valid octets.
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int          LEN_W    = 16,
    parameter logic [15:0] CRC_POLY = 16'h8408,
    parameter logic [15:0] CRC_INIT = 16'hFFFF,
    parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_adapt56,
    input  logic             cfg_bitrev,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             oct_valid,
    input  logic [7:0]       oct_in,
    output logic             oct_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic [1:0]       out_status,
    output logic [LEN_W-1:0] out_len
);
    localparam int HOLD = 2;

    logic             lbit_valid, lbit, hunting;
    logic             frame_open, oct_done, frame_close, frame_abort;
    logic [7:0]       oct_data;
    logic [LEN_W-1:0] oct_count;
    logic [15:0]      crc;
    logic [7:0]       hold_q [HOLD];
    logic [1:0]       held;
    logic             first_pend;
    frame_st_t        st_code;
    logic [LEN_W-1:0] len_code;

    hdlc_rx_ser #(.OCT_W(8)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_adapt56 (cfg_adapt56),
        .cfg_bitrev  (cfg_bitrev),
        .hunting     (hunting),
        .oct_valid   (oct_valid),
        .oct_in      (oct_in),
        .oct_ready   (oct_ready),
        .sbit_valid  (bit_valid),
        .sbit_in     (bit_in),
        .lbit_valid  (lbit_valid),
        .lbit        (lbit)
    );

    hdlc_rx_deframe #(.LEN_W(LEN_W)) u_deframe (
        .clk         (clk),
        .rst_n       (rst_n),
        .lbit_valid  (lbit_valid),
        .lbit        (lbit),
        .hunting     (hunting),
        .frame_open  (frame_open),
        .oct_done    (oct_done),
        .oct_data    (oct_data),
        .frame_close (frame_close),
        .frame_abort (frame_abort),
        .oct_count   (oct_count)
    );

    hdlc_rx_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (frame_open),
        .advance (oct_done),
        .octet   (oct_data),
        .crc     (crc)
    );

    // Classify the frame that ends this cycle.
    always_comb begin
        if (frame_abort) begin
            st_code = FS_ABORT;
        end else if (oct_count < LEN_W'(HOLD)) begin
            st_code = FS_FRAMING;
        end else if (crc != CRC_GOOD) begin
            st_code = FS_CRC;
        end else begin
            st_code = FS_GOOD;
        end
        len_code = (st_code == FS_GOOD) ? oct_count - LEN_W'(HOLD) : oct_count;
    end

    // Hold back two octets, emit the older one and report frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            out_status <= '0;
            out_len    <= '0;
            held       <= '0;
            first_pend <= 1'b0;
            for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            if (frame_close || frame_abort) begin
                out_eof    <= 1'b1;
                out_status <= st_code;
                out_len    <= len_code;
            end
            if (frame_open || frame_abort) begin
                held       <= '0;
                first_pend <= frame_open;
            end else if (oct_done) begin
                if (held == 2'(HOLD)) begin
                    out_valid  <= 1'b1;
                    out_data   <= hold_q[0];
                    out_sof    <= first_pend;
                    first_pend <= 1'b0;
                    hold_q[0]  <= hold_q[1];
                    hold_q[1]  <= oct_data;
                end else begin
                    hold_q[held[0]] <= oct_data;
                    held            <= held + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_chk.sv
// Port-level checker for hdlc_rx, bound into every instance.
// Counts emitted octets per frame to relate them to the frame report.
module hdlc_rx_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oct_valid,
    input logic [7:0]       oct_in,
    input logic             oct_ready,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic [1:0]       out_status,
    input logic [LEN_W-1:0] out_len
);
    logic [LEN_W-1:0] nemit;

    // Count octets emitted since the last frame report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nemit <= '0;
        end else if (out_eof) begin
            nemit <= '0;
        end else if (out_valid) begin
            nemit <= nemit + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_eof && oct_ready));

    // R3
    octet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && oct_ready && oct_in != 8'hFF) |=> !oct_ready);

    // R11
    eof_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> !out_valid);

    // R11
    sof_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && nemit == '0));

    // R10
    good_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && out_status == 2'd0) |-> (out_len == nemit));

    // R9
    framing_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && out_status == 2'd2) |-> (nemit == '0 && out_len < LEN_W'(2)));

endmodule

bind hdlc_rx hdlc_rx_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/hdlc_rx_tb.sv
// Self-checking bench: builds stuffed frame streams, plays them through the
// serial input and through every octet-path configuration, and matches the
// output against expectations computed here.
module hdlc_rx_tb;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_adapt56 = 1'b0;
    logic             cfg_bitrev = 1'b0;
    logic             bit_valid = 1'b0;
    logic             bit_in = 1'b0;
    logic             oct_valid = 1'b0;
    logic [7:0]       oct_in = '0;
    logic             oct_ready;
    logic             out_valid;
    logic [7:0]       out_data;
    logic             out_sof;
    logic             out_eof;
    logic [1:0]       out_status;
    logic [LEN_W-1:0] out_len;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    bit          bq[$];
    int          run1;
    logic [8:0]  exp_b[$];
    string       tag_b[$];
    logic [17:0] exp_e[$];
    string       tag_e[$];

    always #2.5 clk = ~clk;

    hdlc_rx #(.LEN_W(LEN_W)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Compare the output stream against the expectation queues.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (out_valid) begin
                if (exp_b.size() == 0) begin
                    chk(1'b0, "R2", "unexpected octet", {out_sof, out_data}, 0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_b.pop_front();
                    t = tag_b.pop_front();
                    chk({out_sof, out_data} == e, t, "octet {sof,data}", {out_sof, out_data}, e);
                end
            end
            if (out_eof) begin
                if (exp_e.size() == 0) begin
                    chk(1'b0, "R2", "unexpected frame end", {out_status, out_len}, 0);
                end else begin
                    logic [17:0] e;
                    string t;
                    e = exp_e.pop_front();
                    t = tag_e.pop_front();
                    chk({out_status, out_len} == e, t, "frame {status,len}", {out_status, out_len}, e);
                end
            end
        end
    end

    function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = r[0] ^ d[k];
            r = r >> 1;
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    function automatic logic [7:0] pick(input int s, input int i);
        logic [7:0] tbl [8];
        tbl = '{8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'h00, 8'hA5, 8'h1F, 8'hC3};
        return tbl[(s + 3 * i) % 8];
    endfunction

    task automatic raw(input bit b);
        bq.push_back(b);
    endtask

    task automatic push_flag();
        raw(0);
        for (int i = 0; i < 6; i++) raw(1);
        raw(0);
        run1 = 0;
    endtask

    task automatic pad_ones(input int n);
        for (int i = 0; i < n; i++) raw(1);
    endtask

    // R4: insert a 0 after five data 1s; R7: least significant bit first.
    task automatic push_octet(input logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            raw(b[k]);
            if (b[k]) begin
                run1++;
                if (run1 == 5) begin
                    raw(0);
                    run1 = 0;
                end
            end else begin
                run1 = 0;
            end
        end
    endtask

    // kind: 0 good, 1 bad check, 2 one octet only, 3 abort.
    task automatic add_frame(input int kind, input int n, input int seed,
                             input string tag, input bit opening, input bit pad);
        logic [15:0] c;
        logic [15:0] fcs;
        logic [7:0]  b;
        c = 16'hFFFF;
        if (opening) push_flag();
        for (int i = 0; i < n; i++) begin
            b = pick(seed, i);
            push_octet(b);
            c = crc_bits(c, b);
            if (kind <= 1 || (kind == 3 && i < n - 2)) begin
                exp_b.push_back({(i == 0), b});
                tag_b.push_back(tag);
            end
        end
        if (kind <= 1) begin
            fcs = ~c;
            if (kind == 1) fcs[0] = ~fcs[0];
            push_octet(fcs[7:0]);
            push_octet(fcs[15:8]);
            push_flag();
            exp_e.push_back(kind == 0 ? {2'd0, 16'(n)} : {2'd1, 16'(n + 2)});
            tag_e.push_back(tag);
        end else if (kind == 2) begin
            push_flag();
            exp_e.push_back({2'd2, 16'(n)});
            tag_e.push_back(tag);
        end else begin
            pad_ones(8);
            exp_e.push_back({2'd3, 16'(n)});
            tag_e.push_back(tag);
        end
        if (pad) pad_ones(16);
    endtask

    task automatic build_set(input string mtag);
        int g[$];
        g = '{0, 1, 0, 0, 1, 1, 0, 1, 1, 1, 0, 1, 0};
        foreach (g[i]) raw(g[i][0]);
        pad_ones(16);
        for (int n = 0; n <= 6; n++) add_frame(0, n, n, mtag == "" ? (n == 0 ? "R10" : "R4") : mtag, 1, 1);
        add_frame(0, 3, 5, mtag == "" ? "R7" : mtag, 1, 1);
        add_frame(1, 3, 2, mtag == "" ? "R8" : mtag, 1, 1);
        add_frame(2, 1, 4, mtag == "" ? "R9" : mtag, 1, 1);
        add_frame(3, 4, 1, mtag == "" ? "R6" : mtag, 1, 1);
        add_frame(3, 1, 6, mtag == "" ? "R6" : mtag, 1, 1);
        add_frame(0, 2, 3, mtag == "" ? "R5" : mtag, 1, 0);
        add_frame(0, 4, 7, mtag == "" ? "R5" : mtag, 0, 1);
        add_frame(0, 5, 0, mtag == "" ? "R11" : mtag, 1, 1);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
    endtask

    task automatic bit_idle();
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_oct(input logic [7:0] o);
        @(negedge clk);
        while (!oct_ready) @(negedge clk);
        oct_valid = 1'b1;
        oct_in = o;
        @(negedge clk);
        oct_valid = 1'b0;
    endtask

    // R12/R13: pack the bit queue into octets for the chosen configuration.
    task automatic play(input bit octets, input bit m56, input bit rev);
        @(negedge clk);
        cfg_adapt56 = m56;
        cfg_bitrev = rev;
        if (!octets) begin
            foreach (bq[i]) send_bit(bq[i]);
            bit_idle();
        end else begin
            int per;
            bit fill;
            per = m56 ? 7 : 8;
            fill = 1'b0;
            while (bq.size() % per != 0) bq.push_back(1'b1);
            for (int k = 0; k < bq.size(); k += per) begin
                logic [7:0] o;
                o = '0;
                for (int j = 0; j < per; j++) o[rev ? 7 - j : j] = bq[k + j];
                if (m56) begin
                    o[rev ? 0 : 7] = fill;
                    fill = ~fill;
                end
                send_oct(o);
            end
        end
        bq.delete();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!out_valid && !out_eof, "R1", "outputs in reset", {out_valid, out_eof}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_eof && oct_ready, "R1", "outputs after reset",
            {out_valid, out_eof, oct_ready}, 3'b001);
        mon_on = 1'b1;

        build_set("");
        play(1'b0, 1'b0, 1'b0);
        build_set("R11");
        play(1'b1, 1'b0, 1'b0);
        build_set("R13");
        play(1'b1, 1'b0, 1'b1);
        build_set("R12");
        play(1'b1, 1'b1, 1'b0);
        build_set("R12");
        play(1'b1, 1'b1, 1'b1);

        // R3: partial flag, idle octet while hunting, then the flag finishes.
        @(negedge clk);
        cfg_adapt56 = 1'b0;
        cfg_bitrev = 1'b0;
        for (int i = 0; i < 16; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bit_idle();
        send_oct(8'hFF);
        @(negedge clk);
        chk(oct_ready, "R3", "oct_ready after idle octet", oct_ready, 1);
        run1 = 0;
        raw(1);
        raw(0);
        add_frame(0, 2, 1, "R3", 0, 1);
        foreach (bq[i]) send_bit(bq[i]);
        bit_idle();
        bq.delete();
        repeat (40) @(negedge clk);

        chk(exp_b.size() == 0, "R10", "missing octets", exp_b.size(), 0);
        chk(exp_e.size() == 0, "R11", "missing frame ends", exp_e.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule